// File: doc/BRIEF.md
# Clock Interrupt Flag Generator

This block rebuilds the three interrupt sources of a real-time clock (a once-per-second update, a time-of-day alarm and a programmable periodic rate) on top of a single free-running timer count. It holds its own deadline against that count. Each time the count reaches the deadline it makes one base tick. On that tick it works out which sources fire and puts them together into one flag word. It pulses an interrupt line whenever at least one flag is set.

The base tick runs at 64 Hz, which is one `BASE_INTERVAL` of counter steps. A periodic rate at or below 64 Hz is made by counting base ticks. A faster rate instead shortens the tick interval itself. The count is an input, and it can run ahead of the deadline, for example after a long stall. In that case the deadline is stepped forward one interval at a time until it leads the count again. The number of extra steps is reported as missed ticks and is credited to the periodic count. The calendar itself (hours, minutes, seconds) comes from outside and is only compared.

Top module: `clkint_gen`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, `irq_o`, `flags_o`, `missed_o` and `timer_on_o` are all zero.
- R2: On the first rising edge at which any of `upd_en_i`, `alm_en_i`, `per_en_i` is high after all were low, the deadline is set to `count_i + interval` and `timer_on_o` goes high. A tick is taken on the edge where the count has reached the deadline. The interrupt for that tick shows on the second edge after it, so an enable applied just after an edge gives its first interrupt `interval + 3` cycles later while the count advances by one per cycle.
- R3: One edge after all three enables are low, `timer_on_o` is low, and no further tick or interrupt occurs.
- R4: `rate_log2_i` = k selects 2^k Hz, with 0 read as 1 and any value above 13 read as 13. The interval is `BASE_INTERVAL` unless the periodic source is enabled with k > 6, in which case it is `BASE_INTERVAL >> (k-6)`.
- R5: With the periodic source enabled, flag bit 6 is raised once every 2^(6-k) ticks for k ≤ 6, and on every tick for k > 6. The periodic count returns to zero when the flag is raised and while the source is disabled.
- R6: With the update source enabled, flag bit 4 is raised on a tick whose seconds input differs from the remembered seconds, and that value is then remembered. The remembered value starts at 63 after reset.
- R7: With the alarm source enabled, flag bit 5 is raised on a tick where hours, minutes and seconds all equal the alarm inputs.
- R8: On a tick that raises any flag, `flags_o` is loaded with bit 7 set, bits 15:8 equal to 1, bits 6:4 holding the flags and bits 3:0 zero, and `irq_o` is high for exactly one cycle. A tick with no flag leaves `flags_o` unchanged and `irq_o` low.
- R9: On a tick, the deadline advances one interval and then keeps advancing while the count is still past it. `missed_o` shows the number of those extra advances for the latest tick, and with the periodic source enabled they are added to the periodic count.
- R10: All comparisons between count and deadline use the signed difference of the two, so ticks keep their spacing across a count wraparound.
- R11: Two interrupts are never on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | CNT_W | Free-running base timer count |
| upd_en_i | input | 1 | Update source enable |
| alm_en_i | input | 1 | Alarm source enable |
| per_en_i | input | 1 | Periodic source enable |
| rate_log2_i | input | RATE_W | Periodic rate as log2 of Hz |
| now_hr_i | input | 5 | Current hours |
| now_min_i | input | 6 | Current minutes |
| now_sec_i | input | 6 | Current seconds |
| alm_hr_i | input | 5 | Alarm hours |
| alm_min_i | input | 6 | Alarm minutes |
| alm_sec_i | input | 6 | Alarm seconds |
| irq_o | output | 1 | One-cycle interrupt pulse |
| flags_o | output | 16 | Interrupt flag word |
| missed_o | output | LOST_W | Extra deadline advances on the latest tick |
| timer_on_o | output | 1 | Deadline timer running |

## Verification
The assertions assume that the count moves forward by less than half its range between two cycles, and that the interval at the fastest rate stays at two or more counter steps. Only under those conditions do the signed compares and the one-cycle minimum between ticks hold. The stimulus advances the count by one per cycle and adds only a few intervals in its one forward jump. It starts the count just below wraparound. Random rates are kept between 16 Hz and 8192 Hz, and random times are kept inside real calendar ranges.

// File: rtl/clkint_pkg.sv
package clkint_pkg;

   localparam int FLAG_W   = 16;
   localparam int BIT_IRQ  = 7;
   localparam int BIT_PER  = 6;
   localparam int BIT_ALM  = 5;
   localparam int BIT_UPD  = 4;

   typedef enum logic [1:0] {
      DL_OFF   = 2'd0,
      DL_WAIT  = 2'd1,
      DL_CATCH = 2'd2
   } dl_state_t;

   typedef struct packed {
      logic [4:0] hr;
      logic [5:0] mn;
      logic [5:0] sc;
   } hms_t;

endpackage

// File: rtl/clkint_interval.sv
module clkint_interval #(
   parameter int CNT_W         = 32,
   parameter int BASE_INTERVAL = 256,
   parameter int TICK_LOG2     = 6,
   parameter int MAX_LOG2      = 13,
   parameter int RATE_W        = 4,
   parameter int LIM_W         = 6
) (
   input  logic [RATE_W-1:0] rate_log2,
   input  logic              per_en,
   output logic [CNT_W-1:0]  interval,
   output logic [LIM_W-1:0]  limit
);

   localparam logic [CNT_W-1:0] BASE = CNT_W'(BASE_INTERVAL);

   int k;

   always_comb begin
      k = int'(rate_log2);
      if (k < 1)        k = 1;
      if (k > MAX_LOG2) k = MAX_LOG2;
   end

   generate
      if (MAX_LOG2 > TICK_LOG2) begin : g_fast
         always_comb begin
            if (k <= TICK_LOG2) begin
               limit    = LIM_W'(1) << (TICK_LOG2 - k);
               interval = BASE;
            end else begin
               limit    = LIM_W'(1);
               interval = per_en ? (BASE >> (k - TICK_LOG2)) : BASE;
            end
         end
      end else begin : g_slow
         always_comb begin
            limit    = LIM_W'(1) << (TICK_LOG2 - k);
            interval = BASE;
         end
      end
   endgenerate

endmodule

// File: rtl/clkint_deadline.sv
module clkint_deadline
   import clkint_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int LOST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any_en,
   input  logic [CNT_W-1:0]  count,
   input  logic [CNT_W-1:0]  interval,
   output logic              tick,
   output logic [LOST_W-1:0] lost,
   output logic              timer_on
);

   localparam logic [LOST_W-1:0] LOST_MAX = '1;

   dl_state_t         state;
   logic [CNT_W-1:0]  deadline;
   logic [CNT_W-1:0]  diff;
   logic [LOST_W-1:0] lost_acc;
   logic              reached;
   logic              behind;

   always_comb begin
      diff    = count - deadline;
      reached = ($signed(diff) >= 0);
      behind  = ($signed(diff) > 0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= DL_OFF;
         deadline <= '0;
         lost_acc <= '0;
         tick     <= 1'b0;
         lost     <= '0;
      end else begin
         tick <= 1'b0;
         if (!any_en) begin
            state <= DL_OFF;
         end else begin
            case (state)
               DL_OFF: begin
                  deadline <= count + interval;
                  state    <= DL_WAIT;
               end
               DL_WAIT: begin
                  if (reached) begin
                     deadline <= deadline + interval;
                     lost_acc <= '0;
                     state    <= DL_CATCH;
                  end
               end
               DL_CATCH: begin
                  if (behind) begin
                     deadline <= deadline + interval;
                     if (lost_acc != LOST_MAX) lost_acc <= lost_acc + 1'b1;
                  end else begin
                     tick  <= 1'b1;
                     lost  <= lost_acc;
                     state <= DL_WAIT;
                  end
               end
               default: state <= DL_OFF;
            endcase
         end
      end
   end

   assign timer_on = (state != DL_OFF);

endmodule

// File: rtl/clkint_flags.sv
module clkint_flags
   import clkint_pkg::*;
#(
   parameter int LOST_W = 8,
   parameter int LIM_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [LOST_W-1:0] lost,
   input  logic              upd_en,
   input  logic              alm_en,
   input  logic              per_en,
   input  logic [LIM_W-1:0]  limit,
   input  hms_t              now,
   input  hms_t              alarm,
   output logic              irq,
   output logic [FLAG_W-1:0] flags
);

   localparam int SUM_W = ((LOST_W > LIM_W) ? LOST_W : LIM_W) + 2;

   logic [LIM_W-1:0] per_cnt;
   logic [5:0]       last_sec;
   logic [SUM_W-1:0] per_sum;
   logic             upd_hit, alm_hit, per_hit;
   logic [FLAG_W-1:0] word;

   always_comb begin
      per_sum = SUM_W'(per_cnt) + SUM_W'(lost) + SUM_W'(1);
      upd_hit = upd_en && (now.sc != last_sec);
      alm_hit = alm_en && (now == alarm);
      per_hit = per_en && (per_sum >= SUM_W'(limit));
      word            = '0;
      word[15:8]      = 8'd1;
      word[BIT_IRQ]   = 1'b1;
      word[BIT_PER]   = per_hit;
      word[BIT_ALM]   = alm_hit;
      word[BIT_UPD]   = upd_hit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_cnt  <= '0;
         last_sec <= 6'h3F;
         irq      <= 1'b0;
         flags    <= '0;
      end else begin
         irq <= 1'b0;
         if (!per_en) per_cnt <= '0;
         if (tick) begin
            if (upd_hit) last_sec <= now.sc;
            if (per_en) per_cnt <= per_hit ? '0 : per_sum[LIM_W-1:0];
            if (upd_hit || alm_hit || per_hit) begin
               flags <= word;
               irq   <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/clkint_gen.sv
module clkint_gen
   import clkint_pkg::*;
#(
   parameter int CNT_W         = 32,
   parameter int BASE_INTERVAL = 256,
   parameter int TICK_LOG2     = 6,
   parameter int MAX_LOG2      = 13,
   parameter int RATE_W        = 4,
   parameter int LOST_W        = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              upd_en_i,
   input  logic              alm_en_i,
   input  logic              per_en_i,
   input  logic [RATE_W-1:0] rate_log2_i,
   input  logic [4:0]        now_hr_i,
   input  logic [5:0]        now_min_i,
   input  logic [5:0]        now_sec_i,
   input  logic [4:0]        alm_hr_i,
   input  logic [5:0]        alm_min_i,
   input  logic [5:0]        alm_sec_i,
   output logic              irq_o,
   output logic [15:0]       flags_o,
   output logic [LOST_W-1:0] missed_o,
   output logic              timer_on_o
);

   localparam int LIM_W     = TICK_LOG2;
   localparam int FAST_STEP = (MAX_LOG2 > TICK_LOG2) ? (1 << (MAX_LOG2 - TICK_LOG2)) : 1;

   generate
      if (TICK_LOG2 < 1 || MAX_LOG2 < 1) begin : g_bad_log2
         $error("clkint_gen: rate exponents must be at least 1");
      end
      if ((BASE_INTERVAL % FAST_STEP) != 0 || (BASE_INTERVAL / FAST_STEP) < 2) begin : g_bad_base
         $error("clkint_gen: BASE_INTERVAL must divide into intervals of two or more steps");
      end
      if ((1 << RATE_W) <= MAX_LOG2) begin : g_bad_rate_w
         $error("clkint_gen: RATE_W too narrow for MAX_LOG2");
      end
      if (CNT_W < 2 || CNT_W > 62 || BASE_INTERVAL >= (64'd1 << (CNT_W - 1))) begin : g_bad_cnt
         $error("clkint_gen: CNT_W does not hold BASE_INTERVAL as a signed distance");
      end
   endgenerate

   logic              any_en;
   logic [CNT_W-1:0]  interval_w;
   logic [LIM_W-1:0]  limit_w;
   logic              tick_w;
   logic [LOST_W-1:0] lost_w;
   hms_t              now_w, alarm_w;

   assign any_en  = upd_en_i | alm_en_i | per_en_i;
   assign now_w   = '{hr: now_hr_i, mn: now_min_i, sc: now_sec_i};
   assign alarm_w = '{hr: alm_hr_i, mn: alm_min_i, sc: alm_sec_i};

   clkint_interval #(
      .CNT_W(CNT_W), .BASE_INTERVAL(BASE_INTERVAL), .TICK_LOG2(TICK_LOG2),
      .MAX_LOG2(MAX_LOG2), .RATE_W(RATE_W), .LIM_W(LIM_W)
   ) u_interval (
      .rate_log2 (rate_log2_i),
      .per_en    (per_en_i),
      .interval  (interval_w),
      .limit     (limit_w)
   );

   clkint_deadline #(.CNT_W(CNT_W), .LOST_W(LOST_W)) u_deadline (
      .clk      (clk),
      .rst_n    (rst_n),
      .any_en   (any_en),
      .count    (count_i),
      .interval (interval_w),
      .tick     (tick_w),
      .lost     (lost_w),
      .timer_on (timer_on_o)
   );

   clkint_flags #(.LOST_W(LOST_W), .LIM_W(LIM_W)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_w),
      .lost   (lost_w),
      .upd_en (upd_en_i),
      .alm_en (alm_en_i),
      .per_en (per_en_i),
      .limit  (limit_w),
      .now    (now_w),
      .alarm  (alarm_w),
      .irq    (irq_o),
      .flags  (flags_o)
   );

   assign missed_o = lost_w;

endmodule

// File: rtl/clkint_gen_chk.sv
module clkint_gen_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        upd_en_i,
   input logic        alm_en_i,
   input logic        per_en_i,
   input logic        tick_i,
   input logic [16:0] now_i,
   input logic [16:0] alarm_i,
   input logic        irq_o,
   input logic [15:0] flags_o,
   input logic        timer_on_o
);

   // R3
   timer_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_en_i || alm_en_i || per_en_i) |=> !timer_on_o);

   // R3
   no_tick_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !timer_on_o |-> !tick_i);

   // R8
   word_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (flags_o[15:8] == 8'd1) && flags_o[7] && (flags_o[6:4] != 3'b000) && (flags_o[3:0] == 4'd0));

   // R11
   irq_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   // R7
   alarm_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && alm_en_i && (now_i == alarm_i)) |=> (irq_o && flags_o[5]));

   // R2
   arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timer_on_o) |-> $past(upd_en_i || alm_en_i || per_en_i));

endmodule

bind clkint_gen clkint_gen_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .upd_en_i   (upd_en_i),
   .alm_en_i   (alm_en_i),
   .per_en_i   (per_en_i),
   .tick_i     (tick_w),
   .now_i      (now_w),
   .alarm_i    (alarm_w),
   .irq_o      (irq_o),
   .flags_o    (flags_o),
   .timer_on_o (timer_on_o)
);

// File: tb/clkint_gen_bench.sv
`timescale 1ns/1ps
module clkint_gen_bench;

   localparam int BASE = 256;
   localparam logic [15:0] W_UPD = 16'h0190;
   localparam logic [15:0] W_PER = 16'h01C0;
   localparam logic [15:0] W_ALM = 16'h01A0;
   localparam logic [15:0] W_ALL = 16'h01F0;
   localparam logic [15:0] W_PA  = 16'h01E0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cnt_r = 32'hFFFF_FF80;
   logic        upd_en = 1'b0, alm_en = 1'b0, per_en = 1'b0;
   logic [3:0]  rate = 4'd6;
   logic [4:0]  now_hr = 5'd0, alm_hr = 5'd0;
   logic [5:0]  now_min = 6'd0, now_sec = 6'd0, alm_min = 6'd0, alm_sec = 6'd0;
   logic        irq_o;
   logic [15:0] flags_o;
   logic [7:0]  missed_o;
   logic        timer_on_o;

   int total = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   clkint_gen u_clkint_gen (
      .clk(clk), .rst_n(rst_n), .count_i(cnt_r),
      .upd_en_i(upd_en), .alm_en_i(alm_en), .per_en_i(per_en), .rate_log2_i(rate),
      .now_hr_i(now_hr), .now_min_i(now_min), .now_sec_i(now_sec),
      .alm_hr_i(alm_hr), .alm_min_i(alm_min), .alm_sec_i(alm_sec),
      .irq_o(irq_o), .flags_o(flags_o), .missed_o(missed_o), .timer_on_o(timer_on_o)
   );

   function automatic int exp_gap(input int k);
      int kk;
      kk = (k < 1) ? 1 : ((k > 13) ? 13 : k);
      if (kk <= 6) return (1 << (6 - kk)) * BASE;
      return BASE >> (kk - 6);
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      cnt_r = cnt_r + 32'd1;
      cycles++;
   endtask

   task automatic wait_irq(input int maxc, output int n);
      n = -1;
      for (int i = 1; i <= maxc; i++) begin
         step();
         if (irq_o) begin
            n = i;
            break;
         end
      end
   endtask

   task automatic quiet(input int c, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < c; i++) begin
         step();
         if (irq_o) seen = 1'b1;
      end
   endtask

   task automatic all_off();
      upd_en = 1'b0; alm_en = 1'b0; per_en = 1'b0;
      step(); step(); step();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < 190000; i++) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      finish_run();
   end

   initial begin
      int n;
      bit seen;
      int k, g;
      logic [4:0] h;
      logic [5:0] m, s;
      bit match;
      void'($urandom(32'd1234));

      // R1 reset state
      step(); step(); step();
      check(!irq_o && flags_o == 16'h0 && missed_o == 8'h0 && !timer_on_o,
            "R1 in reset", {irq_o, flags_o, missed_o, timer_on_o}, 0);
      rst_n = 1'b1;
      step();
      check(!irq_o && flags_o == 16'h0 && missed_o == 8'h0 && !timer_on_o,
            "R1 after release", {irq_o, flags_o, missed_o, timer_on_o}, 0);

      // R6 update source, first tick crosses count wraparound (R10, R2 timing)
      now_sec = 6'd5;
      upd_en = 1'b1;
      wait_irq(2000, n);
      check(n == BASE + 3, "R2 R10 arm delay", n, BASE + 3);
      check(flags_o == W_UPD, "R6 first update word", flags_o, W_UPD);
      quiet(3 * BASE, seen);
      check(!seen, "R6 no update with stable seconds", seen, 0);
      now_sec = 6'd6;
      wait_irq(BASE + 8, n);
      check(n > 0 && flags_o == W_UPD, "R6 update on new second", flags_o, W_UPD);
      all_off();

      // R3 disable
      check(!timer_on_o, "R3 timer off", timer_on_o, 0);
      now_sec = 6'd9;
      quiet(2 * BASE + 8, seen);
      check(!seen, "R3 no interrupt while off", seen, 0);

      // R5 periodic at 16 Hz: every 4 ticks
      rate = 4'd4;
      per_en = 1'b1;
      wait_irq(8000, n);
      wait_irq(8000, n);
      check(n == 4 * BASE, "R5 16 Hz spacing", n, 4 * BASE);
      check(flags_o == W_PER, "R5 periodic word", flags_o, W_PER);

      // R9 missed ticks credited: jump three intervals ahead
      cnt_r = cnt_r + 32'(3 * BASE);
      for (int i = 0; i < 8; i++) step();
      check(missed_o == 8'd2, "R9 missed count", missed_o, 2);
      wait_irq(8000, n);
      check(n == 4 * BASE - 3 * BASE - 8, "R9 credit shortens wait", n, BASE - 8);
      wait_irq(8000, n);
      check(missed_o == 8'd0, "R9 missed clears on clean tick", missed_o, 0);
      all_off();

      // R4 rate clamp above 13
      rate = 4'd15;
      per_en = 1'b1;
      wait_irq(2000, n);
      wait_irq(200, n);
      wait_irq(200, n);
      check(n == 2, "R4 clamp to 8192 Hz", n, 2);
      all_off();

      // R2 arm delay on periodic 64 Hz, R8 word
      rate = 4'd6;
      per_en = 1'b1;
      wait_irq(2000, n);
      check(n == BASE + 3, "R2 arm delay periodic", n, BASE + 3);
      check(flags_o == W_PER, "R8 periodic word fields", flags_o, W_PER);
      all_off();

      // R7 R8 all sources at once
      now_hr = 5'd13; now_min = 6'd45; now_sec = 6'd7;
      alm_hr = 5'd13; alm_min = 6'd45; alm_sec = 6'd7;
      upd_en = 1'b1; alm_en = 1'b1; per_en = 1'b1;
      wait_irq(2000, n);
      check(flags_o == W_ALL, "R8 all flags word", flags_o, W_ALL);
      wait_irq(2000, n);
      check(n == BASE && flags_o == W_PA, "R7 alarm and periodic, no update", flags_o, W_PA);
      all_off();

      // R4 R5 random rates
      for (int it = 0; it < 6; it++) begin
         k = 4 + int'($urandom % 10);
         g = exp_gap(k);
         rate = 4'(k);
         per_en = 1'b1;
         wait_irq(8000, n);
         wait_irq(8000, n);
         wait_irq(8000, n);
         check(n == g, $sformatf("R4 R5 rate 2^%0d spacing", k), n, g);
         check(flags_o == W_PER, "R5 random rate word", flags_o, W_PER);
         all_off();
      end

      // R7 random alarm match and near miss
      for (int it = 0; it < 4; it++) begin
         h = 5'($urandom % 24); m = 6'($urandom % 60); s = 6'($urandom % 60);
         match = 1'($urandom % 2);
         now_hr = h; now_min = m; now_sec = s;
         alm_hr = h; alm_sec = s;
         alm_min = match ? m : 6'((m + 1) % 60);
         alm_en = 1'b1;
         if (match) begin
            wait_irq(2000, n);
            check(n == BASE + 3 && flags_o == W_ALM, "R7 alarm match", flags_o, W_ALM);
         end else begin
            quiet(2 * BASE + 8, seen);
            check(!seen && timer_on_o, "R7 alarm near miss", seen, 0);
         end
         all_off();
      end

      finish_run();
   end

endmodule